// File: doc/BRIEF.md
# Circular Message Queue Pointer

This block holds the write pointer for a 64-word message queue that lives in a shared RAM. A message sequencer uses the queue to hand values to a host. The pointer is one 16-bit register with two fields. The upper field is a base address that the host can move. The low six bits are a write offset that only the push engine changes. The host reads the whole register at any time. Bit 15 and the offset bits cannot be set by a host write.

A push request chooses one of four sources for the word it stores: an immediate value, the status word of the latest message, the current time-tag count, or a word fetched from a RAM address. The word is written at base plus offset. The offset then steps by one and wraps from 63 back to 0, so the base field never changes during pushes. The first three sources finish in the cycle of the request. A fetch push spends one extra cycle in which the RAM read data is written, and a busy output is high for that cycle.

Top module: `msg_queue_ptr`

## Requirements
- R1: After reset, `ptrRd` reads 0x00C0, `busy` is 0 and no RAM access is issued.
- R2: A host write loads bits 14 to 6 of `hostWrData` into the base field. Bit 15 and bits 5 to 0 of `ptrRd` read 0 regardless of the data written.
- R3: A host write sets the offset to 0, so the next push goes to the new base address.
- R4: With `busy` low, a push with `pushSrc` 0 (immediate, `immData`), 1 (status, `statusWord`) or 2 (time tag, `timeTag`) raises `ramWrEn` in the same cycle. The address is the current `ptrRd` and the data is the selected input.
- R5: Each completed push adds 1 to the offset modulo 64 and leaves bits 15 to 6 unchanged. After 64 pushes the pointer is back at its base.
- R6: A push with `pushSrc` 3 raises `ramRdEn` with `ramRdAddr` = `srcAddr` in the request cycle. In the next cycle `busy` is 1 and `ramWrEn` writes `ramRdData` at the current pointer. The RAM read latency is one cycle.
- R7: A push request made while `busy` is 1 is ignored: it issues no read, does not change the word being written, and does not advance the pointer.
- R8: When a host write and a push request arrive in the same idle cycle, the host write takes effect and the push is dropped, with no RAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Host write strobe for the pointer register |
| hostWrData | input | 16 | Host write data |
| ptrRd | output | 16 | Pointer register value (base and offset) |
| pushReq | input | 1 | Push request from the sequencer |
| pushSrc | input | 2 | Push source: 0 immediate, 1 status, 2 time tag, 3 memory |
| immData | input | 16 | Immediate data word |
| statusWord | input | 16 | Status word of the latest message |
| timeTag | input | 16 | Current time-tag count |
| srcAddr | input | 16 | RAM address for a memory-source push |
| busy | output | 1 | High during the write cycle of a memory-source push |
| ramRdEn | output | 1 | RAM read strobe |
| ramRdAddr | output | 16 | RAM read address |
| ramRdData | input | 16 | RAM read data, valid one cycle after the read strobe |
| ramWrEn | output | 1 | RAM write strobe |
| ramWrAddr | output | 16 | RAM write address |
| ramWrData | output | 16 | RAM write data |

## Verification
The assertions assume the RAM returns read data exactly one cycle after `ramRdEn`. They also assume the sequencer keeps `pushSrc` and its data inputs steady within the cycle it samples them. The bench RAM model returns a registered function of the read address, which meets the latency assumption. The stimulus never issues a host write during a busy cycle, so the ordering of a fetch write against a base change is left unexercised. It does drive a push request during a busy cycle and a host write together with an idle push request, and checks both outcomes at the ports.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  typedef enum logic [1:0] {
    SRC_IMM    = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_TIME   = 2'd2,
    SRC_MEM    = 2'd3
  } push_src_e;

  typedef struct packed {
    logic      loadBase;
    logic      advance;
    logic      wrStrobe;
    logic      rdStrobe;
    push_src_e dataSel;
  } ctrl_strobe_t;
endpackage

// File: rtl/msgq_ctrl.sv
module msgq_ctrl
  import msgq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostWrEn,
  input  logic         pushReq,
  input  logic [1:0]   pushSrc,
  output ctrl_strobe_t strobe,
  output logic         busy
);
  typedef enum logic {ST_IDLE, ST_FETCH} state_e;
  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe         = '0;
    strobe.dataSel = push_src_e'(pushSrc);
    nextState      = state;
    case (state)
      ST_IDLE: begin
        if (hostWrEn) begin
          strobe.loadBase = 1'b1;
        end else if (pushReq) begin
          if (push_src_e'(pushSrc) == SRC_MEM) begin
            strobe.rdStrobe = 1'b1;
            nextState       = ST_FETCH;
          end else begin
            strobe.wrStrobe = 1'b1;
            strobe.advance  = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        strobe.wrStrobe = 1'b1;
        strobe.advance  = 1'b1;
        strobe.dataSel  = SRC_MEM;
        strobe.loadBase = hostWrEn;
        nextState       = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_FETCH);

  p_fetch_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdStrobe |=> (busy && strobe.wrStrobe && strobe.dataSel == SRC_MEM));

  p_busy_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && pushReq) |-> !strobe.rdStrobe);

  p_host_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !busy) |-> (!strobe.wrStrobe && !strobe.rdStrobe));
endmodule

// File: rtl/msgq_datapath.sv
module msgq_datapath
  import msgq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int OFF_W     = 6,
  parameter logic [ADDR_W-1:0] RESET_PTR = 16'h00C0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [ADDR_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] immData,
  input  logic [DATA_W-1:0] statusWord,
  input  logic [DATA_W-1:0] timeTag,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [ADDR_W-1:0] ptrValue,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramRdAddr
);
  localparam int BASE_W = ADDR_W - 1 - OFF_W;
  localparam logic [BASE_W-1:0] RESET_BASE = RESET_PTR[ADDR_W-2:OFF_W];

  logic [BASE_W-1:0] base;
  logic [OFF_W-1:0]  offset;
  logic              unusedHostBits;

  assign unusedHostBits = ^{hostWrData[ADDR_W-1], hostWrData[OFF_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base   <= RESET_BASE;
      offset <= '0;
    end else if (strobe.loadBase) begin
      base   <= hostWrData[ADDR_W-2:OFF_W];
      offset <= '0;
    end else if (strobe.advance) begin
      offset <= offset + 1'b1;
    end
  end

  assign ptrValue = {1'b0, base, offset};

  always_comb begin
    case (strobe.dataSel)
      SRC_IMM:    ramWrData = immData;
      SRC_STATUS: ramWrData = statusWord;
      SRC_TIME:   ramWrData = timeTag;
      default:    ramWrData = ramRdData;
    endcase
  end

  assign ramWrEn   = strobe.wrStrobe;
  assign ramWrAddr = ptrValue;
  assign ramRdEn   = strobe.rdStrobe;
  assign ramRdAddr = srcAddr;

  p_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBase |=> (ptrValue[ADDR_W-2:OFF_W] == $past(hostWrData[ADDR_W-2:OFF_W])));

  p_offset_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBase |=> (ptrValue[OFF_W-1:0] == '0));

  p_advance_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.loadBase) |=>
      ((ptrValue[OFF_W-1:0] == OFF_W'($past(ptrValue[OFF_W-1:0]) + 1'b1))
       && $stable(ptrValue[ADDR_W-1:OFF_W])));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.loadBase) |=> $stable(ptrValue));
endmodule

// File: rtl/msg_queue_ptr.sv
module msg_queue_ptr
  import msgq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 6,
  parameter logic [ADDR_W-1:0] RESET_PTR = 16'h00C0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostWrData,
  output logic [ADDR_W-1:0] ptrRd,
  input  logic              pushReq,
  input  logic [1:0]        pushSrc,
  input  logic [DATA_W-1:0] immData,
  input  logic [DATA_W-1:0] statusWord,
  input  logic [DATA_W-1:0] timeTag,
  input  logic [ADDR_W-1:0] srcAddr,
  output logic              busy,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramRdAddr,
  input  logic [DATA_W-1:0] ramRdData,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [DATA_W-1:0] ramWrData
);
  ctrl_strobe_t strobe;

  msgq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWrEn (hostWrEn),
    .pushReq  (pushReq),
    .pushSrc  (pushSrc),
    .strobe   (strobe),
    .busy     (busy)
  );

  msgq_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .OFF_W     (OFF_W),
    .RESET_PTR (RESET_PTR)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostWrData (hostWrData),
    .immData    (immData),
    .statusWord (statusWord),
    .timeTag    (timeTag),
    .srcAddr    (srcAddr),
    .ramRdData  (ramRdData),
    .ptrValue   (ptrRd),
    .ramWrEn    (ramWrEn),
    .ramWrAddr  (ramWrAddr),
    .ramWrData  (ramWrData),
    .ramRdEn    (ramRdEn),
    .ramRdAddr  (ramRdAddr)
  );

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ramRdEn);
endmodule

// File: tb/msg_queue_ptr_test.sv
module msg_queue_ptr_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] ptrRd;
  logic        pushReq = 1'b0;
  logic [1:0]  pushSrc = 2'd0;
  logic [15:0] immData = '0;
  logic [15:0] statusWord = '0;
  logic [15:0] timeTag = '0;
  logic [15:0] srcAddr = '0;
  logic        busy;
  logic        ramRdEn;
  logic [15:0] ramRdAddr;
  logic [15:0] ramRdData = '0;
  logic        ramWrEn;
  logic [15:0] ramWrAddr;
  logic [15:0] ramWrData;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [15:0] expPtr;

  always #(CLK_PERIOD/2) clk = ~clk;

  // RAM model: one-cycle read latency, data is a function of the address
  always @(posedge clk) if (ramRdEn) ramRdData <= ramRdAddr ^ 16'h5A5A;

  msg_queue_ptr uut (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nextPtr(input logic [15:0] p);
    return {p[15:6], 6'(p[5:0] + 1'b1)};
  endfunction

  task automatic t_reset();
    check("R1 ptrRd", ptrRd, 16'h00C0);
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 ramWrEn", {15'd0, ramWrEn}, 16'd0);
    check("R1 ramRdEn", {15'd0, ramRdEn}, 16'd0);
    expPtr = 16'h00C0;
  endtask

  task automatic hostWrite(input logic [15:0] d);
    @(negedge clk); hostWrEn = 1'b1; hostWrData = d;
    @(negedge clk); hostWrEn = 1'b0;
    #1;
  endtask

  task automatic t_host_mask();
    hostWrite(16'hFFFF);
    check("R2 write FFFF", ptrRd, 16'h7FC0);
    hostWrite(16'h1234);
    check("R2 write 1234", ptrRd, 16'h1200);
    expPtr = 16'h1200;
  endtask

  task automatic pushOne(input logic [1:0] src, input logic [15:0] expData, input string tag);
    @(negedge clk); pushReq = 1'b1; pushSrc = src;
    #1;
    check({tag, " wrEn"}, {15'd0, ramWrEn}, 16'd1);
    check({tag, " wrAddr"}, ramWrAddr, expPtr);
    check({tag, " wrData"}, ramWrData, expData);
    @(negedge clk); pushReq = 1'b0;
    expPtr = nextPtr(expPtr);
    #1;
    check("R5 advance", ptrRd, expPtr);
  endtask

  task automatic t_sources();
    immData = 16'hA001; statusWord = 16'hB002; timeTag = 16'hC003;
    pushOne(2'd0, 16'hA001, "R4 imm");
    pushOne(2'd1, 16'hB002, "R4 status");
    pushOne(2'd2, 16'hC003, "R4 time");
  endtask

  task automatic t_offset_clear();
    hostWrite(16'h1200);
    expPtr = 16'h1200;
    check("R3 offset cleared", ptrRd, 16'h1200);
    pushOne(2'd0, immData, "R3 push at base");
  endtask

  task automatic t_mem_push();
    srcAddr = 16'h0123; immData = 16'hDEAD;
    @(negedge clk); pushReq = 1'b1; pushSrc = 2'd3;
    #1;
    check("R6 rdEn", {15'd0, ramRdEn}, 16'd1);
    check("R6 rdAddr", ramRdAddr, 16'h0123);
    check("R6 no write yet", {15'd0, ramWrEn}, 16'd0);
    // request an immediate push while busy: must be ignored (R7)
    @(negedge clk); pushSrc = 2'd0;
    #1;
    check("R6 busy", {15'd0, busy}, 16'd1);
    check("R6 wrEn", {15'd0, ramWrEn}, 16'd1);
    check("R6 wrAddr", ramWrAddr, expPtr);
    check("R7 data from fetch", ramWrData, 16'h5B79);
    check("R7 no read", {15'd0, ramRdEn}, 16'd0);
    @(negedge clk); pushReq = 1'b0;
    expPtr = nextPtr(expPtr);
    #1;
    check("R7 busy done", {15'd0, busy}, 16'd0);
    check("R7 single advance", ptrRd, expPtr);
  endtask

  task automatic t_collision();
    @(negedge clk); pushReq = 1'b1; pushSrc = 2'd0; hostWrEn = 1'b1; hostWrData = 16'h2A80;
    #1;
    check("R8 no write", {15'd0, ramWrEn}, 16'd0);
    check("R8 no read", {15'd0, ramRdEn}, 16'd0);
    @(negedge clk); pushReq = 1'b0; hostWrEn = 1'b0;
    #1;
    check("R8 host wins", ptrRd, 16'h2A80);
    expPtr = 16'h2A80;
  endtask

  task automatic t_wrap();
    hostWrite(16'h0400);
    expPtr = 16'h0400;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); pushReq = 1'b1; pushSrc = 2'd2; timeTag = 16'(i);
      #1;
      check("R5 wrap addr", ramWrAddr, 16'h0400 + 16'(i));
      expPtr = nextPtr(expPtr);
    end
    @(negedge clk); pushReq = 1'b0;
    #1;
    check("R5 wrapped to base", ptrRd, 16'h0400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_host_mask();
    t_sources();
    t_offset_clear();
    t_mem_push();
    t_collision();
    t_wrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule